// File: doc/BRIEF.md
# Exception Entry Controller

This block decides what happens to the processor state in the cycle a synchronous exception or a debug event is taken. A general exception request brings a cause code, the faulting program counter and, for address-carrying faults, a virtual address. A debug request brings a debug cause and the same program counter. In one clock edge the block saves the program counter, records the cause, updates the status word and raises a one-cycle vector select that tells the fetch logic which handler to enter: user, kernel, double-exception or debug.

The choice between handlers follows the status word. While the exception-mode flag is clear, the user-mode flag picks the user or kernel handler. While the flag is set, any new exception is a double exception. A debug event is taken only when the current interrupt level is below the configured debug level. On entry it stores the program counter and the old status into the save pair for that level, then raises the interrupt level to the debug level. A general exception and a debug request in the same cycle resolve in favour of the exception.

A register-index port lets software, or a bench, preload and read back every saved register. In the status word the interrupt level sits in bits [3:0], the exception-mode flag in bit 4 and the user-mode flag in bit 5.

Top module: `exc_entry_top`

## Requirements
- R1: After reset every register reachable through the read port is zero, and vec_sel is zero.
- R2: An exception request taken while status bit 4 is 0 writes evt_pc into register index 5 (first-level PC save). It selects the user vector (vec_sel bit 0) when status bit 5 is 1 and the kernel vector (vec_sel bit 1) when it is 0.
- R3: An exception request taken while status bit 4 is 1 selects the double vector (vec_sel bit 2). With HAS_DEPC=1 it writes evt_pc into index 4 and leaves index 5 unchanged. With HAS_DEPC=0 it writes evt_pc into index 5, and index 4 always reads zero.
- R4: Every taken exception writes exc_cause, zero-extended, into index 1 (cause). It sets status bit 4 and leaves every other status bit unchanged.
- R5: The faulting address register (index 2) takes exc_vaddr only on an exception with exc_has_vaddr=1. Otherwise it holds its value, apart from software writes.
- R6: A debug request with status[3:0] >= DBG_LEVEL, or one that arrives together with an exception request, changes no register and produces no debug vector.
- R7: A debug request with status[3:0] < DBG_LEVEL and no exception request writes dbg_cause, zero-extended, into index 3. It writes evt_pc into index 4+DBG_LEVEL and the old status into index 9+DBG_LEVEL. It sets status[3:0] to DBG_LEVEL and sets bit 4, keeping the other status bits, and selects the debug vector (vec_sel bit 3).
- R8: When an exception request and a debug request arrive in the same cycle, only the exception is taken.
- R9: vec_sel is one-hot or zero. It pulses in the cycle after the edge that takes an event and is zero after any cycle with no event.
- R10: Register indices are 0 status, 1 cause, 2 vaddr, 3 debug cause, 4 double-exception PC, 4+L the PC save for level L (L=1..6), and 9+L the saved status for level L (L=2..6). A software write (sw_we) lands at the next edge unless an event is taken in that cycle, in which case it is dropped. rd_data shows the register named by rd_idx combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_req | input | 1 | General exception request strobe |
| exc_has_vaddr | input | 1 | Request also carries a faulting address |
| exc_cause | input | CAUSE_W | Exception cause code |
| evt_pc | input | XLEN | Program counter of the faulting or debugged instruction |
| exc_vaddr | input | XLEN | Faulting virtual address |
| dbg_req | input | 1 | Debug request strobe |
| dbg_cause | input | DCAUSE_W | Debug cause code |
| sw_we | input | 1 | Software register write enable |
| sw_idx | input | 4 | Software write register index |
| sw_wdata | input | XLEN | Software write data |
| rd_idx | input | 4 | Read port register index |
| rd_data | output | XLEN | Read port data |
| status_o | output | XLEN | Current status word |
| cause_o | output | XLEN | Current cause register |
| vaddr_o | output | XLEN | Current faulting address register |
| vec_sel | output | 4 | One-hot vector select: 0 user, 1 kernel, 2 double, 3 debug |

## Verification
Directed cases cover each combination of the exception-mode and user-mode flags, so a swapped priority between the two flags shows up as a wrong vector. They also place the interrupt level one below and exactly at the debug level, which exposes an off-by-one in the acceptance compare. Simultaneous requests and software writes that land on an event cycle check that priority is applied and that dropped writes really are dropped. Random cycles preload random status words and mix the request kinds. For each one a bench model predicts every output and a randomly chosen read-port register, which catches a write sent to the wrong level index or a status bit that gets clobbered.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN     = 32;
  localparam int NREG     = 16;
  localparam int IDX_W    = 4;
  localparam int IL_W     = 4;
  localparam int EXCM_BIT = 4;
  localparam int UM_BIT   = 5;

  localparam logic [IDX_W-1:0] IDX_STATUS = 4'd0;
  localparam logic [IDX_W-1:0] IDX_CAUSE  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_VADDR  = 4'd2;
  localparam logic [IDX_W-1:0] IDX_DCAUSE = 4'd3;
  localparam logic [IDX_W-1:0] IDX_DEPC   = 4'd4;
  localparam logic [IDX_W-1:0] IDX_EPC1   = 4'd5;

  localparam int VEC_USER   = 0;
  localparam int VEC_KERNEL = 1;
  localparam int VEC_DOUBLE = 2;
  localparam int VEC_DEBUG  = 3;

  function automatic logic [IDX_W-1:0] pc_slot(input int lvl);
    return IDX_W'(4 + lvl);
  endfunction

  function automatic logic [IDX_W-1:0] ps_slot(input int lvl);
    return IDX_W'(9 + lvl);
  endfunction

  function automatic logic [3:0] pick_vec(input logic excm, input logic um);
    logic [3:0] v;
    v = '0;
    if (excm)    v[VEC_DOUBLE] = 1'b1;
    else if (um) v[VEC_USER]   = 1'b1;
    else         v[VEC_KERNEL] = 1'b1;
    return v;
  endfunction

  function automatic logic [XLEN-1:0] dbg_status(input logic [XLEN-1:0] old,
                                                 input int lvl);
    logic [XLEN-1:0] s;
    s = old;
    s[IL_W-1:0] = IL_W'(lvl);
    s[EXCM_BIT] = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/exc_decide.sv
module exc_decide
  import exc_pkg::*;
#(
  parameter int DBG_LEVEL = 4,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic            exc_req,
  input  logic            dbg_req,
  input  logic [IL_W-1:0] cur_il,
  input  logic            cur_excm,
  input  logic            cur_um,
  output logic            take_exc,
  output logic            take_dbg,
  output logic            wr_depc,
  output logic            wr_epc1,
  output logic [3:0]      vec_next
);
  localparam logic [IL_W-1:0] LVL_V = IL_W'(DBG_LEVEL);

  logic dbg_allowed;

  always_comb begin
    dbg_allowed = cur_il < LVL_V;
    take_exc    = exc_req;
    take_dbg    = dbg_req && !exc_req && dbg_allowed;
    wr_depc     = take_exc && cur_excm && HAS_DEPC;
    wr_epc1     = take_exc && !(cur_excm && HAS_DEPC);
    vec_next    = '0;
    if (take_exc)      vec_next = pick_vec(cur_excm, cur_um);
    else if (take_dbg) vec_next[VEC_DEBUG] = 1'b1;
  end
endmodule

// File: rtl/exc_sreg_bank.sv
module exc_sreg_bank
  import exc_pkg::*;
#(
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREG-1:0]            hw_we,
  input  logic [NREG-1:0][XLEN-1:0]  hw_d,
  input  logic                       sw_we,
  input  logic [IDX_W-1:0]           sw_idx,
  input  logic [XLEN-1:0]            sw_wdata,
  output logic [NREG-1:0][XLEN-1:0]  q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == int'(IDX_DEPC) && !HAS_DEPC) begin : g_absent
      assign q[i] = '0;
    end else begin : g_present
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               q[i] <= '0;
        else if (hw_we[i])                        q[i] <= hw_d[i];
        else if (sw_we && sw_idx == IDX_W'(i))    q[i] <= sw_wdata;
      end
    end
  end
endmodule

// File: rtl/exc_entry_top.sv
module exc_entry_top
  import exc_pkg::*;
#(
  parameter int DBG_LEVEL = 4,
  parameter bit HAS_DEPC  = 1'b1,
  parameter int CAUSE_W   = 6,
  parameter int DCAUSE_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_req,
  input  logic                exc_has_vaddr,
  input  logic [CAUSE_W-1:0]  exc_cause,
  input  logic [XLEN-1:0]     evt_pc,
  input  logic [XLEN-1:0]     exc_vaddr,
  input  logic                dbg_req,
  input  logic [DCAUSE_W-1:0] dbg_cause,
  input  logic                sw_we,
  input  logic [IDX_W-1:0]    sw_idx,
  input  logic [XLEN-1:0]     sw_wdata,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [XLEN-1:0]     rd_data,
  output logic [XLEN-1:0]     status_o,
  output logic [XLEN-1:0]     cause_o,
  output logic [XLEN-1:0]     vaddr_o,
  output logic [3:0]          vec_sel
);
  localparam logic [IDX_W-1:0] DBG_PC_IDX = pc_slot(DBG_LEVEL);
  localparam logic [IDX_W-1:0] DBG_PS_IDX = ps_slot(DBG_LEVEL);
  localparam logic [IL_W-1:0]  LVL_V      = IL_W'(DBG_LEVEL);

  logic [NREG-1:0][XLEN-1:0] regs;
  logic [NREG-1:0]           hw_we;
  logic [NREG-1:0][XLEN-1:0] hw_d;
  logic take_exc, take_dbg, wr_depc, wr_epc1, evt_taken, sw_we_eff;
  logic [3:0] vec_next;
  logic [XLEN-1:0] status_exc;

  assign status_o = regs[IDX_STATUS];
  assign cause_o  = regs[IDX_CAUSE];
  assign vaddr_o  = regs[IDX_VADDR];
  assign rd_data  = regs[rd_idx];

  exc_decide #(.DBG_LEVEL(DBG_LEVEL), .HAS_DEPC(HAS_DEPC)) u_decide (
    .exc_req  (exc_req),
    .dbg_req  (dbg_req),
    .cur_il   (status_o[IL_W-1:0]),
    .cur_excm (status_o[EXCM_BIT]),
    .cur_um   (status_o[UM_BIT]),
    .take_exc (take_exc),
    .take_dbg (take_dbg),
    .wr_depc  (wr_depc),
    .wr_epc1  (wr_epc1),
    .vec_next (vec_next)
  );

  assign evt_taken = take_exc || take_dbg;
  assign sw_we_eff = sw_we && !evt_taken;

  always_comb begin
    status_exc = status_o;
    status_exc[EXCM_BIT] = 1'b1;
    hw_we = '0;
    hw_d  = '0;
    if (take_exc) begin
      hw_we[IDX_STATUS] = 1'b1;
      hw_d[IDX_STATUS]  = status_exc;
      hw_we[IDX_CAUSE]  = 1'b1;
      hw_d[IDX_CAUSE]   = XLEN'(exc_cause);
      if (exc_has_vaddr) begin
        hw_we[IDX_VADDR] = 1'b1;
        hw_d[IDX_VADDR]  = exc_vaddr;
      end
      if (wr_depc) begin
        hw_we[IDX_DEPC] = 1'b1;
        hw_d[IDX_DEPC]  = evt_pc;
      end
      if (wr_epc1) begin
        hw_we[IDX_EPC1] = 1'b1;
        hw_d[IDX_EPC1]  = evt_pc;
      end
    end else if (take_dbg) begin
      hw_we[IDX_DCAUSE] = 1'b1;
      hw_d[IDX_DCAUSE]  = XLEN'(dbg_cause);
      hw_we[DBG_PC_IDX] = 1'b1;
      hw_d[DBG_PC_IDX]  = evt_pc;
      hw_we[DBG_PS_IDX] = 1'b1;
      hw_d[DBG_PS_IDX]  = status_o;
      hw_we[IDX_STATUS] = 1'b1;
      hw_d[IDX_STATUS]  = dbg_status(status_o, DBG_LEVEL);
    end
  end

  exc_sreg_bank #(.HAS_DEPC(HAS_DEPC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_we    (hw_we),
    .hw_d     (hw_d),
    .sw_we    (sw_we_eff),
    .sw_idx   (sw_idx),
    .sw_wdata (sw_wdata),
    .q        (regs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_sel <= '0;
    else        vec_sel <= vec_next;
  end

  // Assertions
  p_vec_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_sel));

  p_quiet_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !dbg_req) |=> (vec_sel == 4'b0));

  p_user_kernel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !status_o[EXCM_BIT]) |=>
      (vec_sel[VEC_USER] == $past(status_o[UM_BIT])) &&
      (vec_sel[VEC_KERNEL] == !$past(status_o[UM_BIT])) &&
      (regs[IDX_EPC1] == $past(evt_pc)));

  p_double_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && status_o[EXCM_BIT]) |=> vec_sel[VEC_DOUBLE]);

  p_excm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> status_o[EXCM_BIT] &&
      (cause_o == XLEN'($past(exc_cause))));

  p_vaddr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(exc_req && exc_has_vaddr) && !(sw_we && sw_idx == IDX_VADDR))
      |=> $stable(vaddr_o));

  p_dbg_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !exc_req && status_o[IL_W-1:0] >= LVL_V && !sw_we)
      |=> (vec_sel == 4'b0) && $stable(status_o));

  p_dbg_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !exc_req && status_o[IL_W-1:0] < LVL_V) |=>
      (status_o[IL_W-1:0] == LVL_V) && status_o[EXCM_BIT] &&
      vec_sel[VEC_DEBUG] && (regs[DBG_PS_IDX] == $past(status_o)));

  p_exc_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> !vec_sel[VEC_DEBUG]);
endmodule

// File: tb/exc_entry_top_test.sv
module exc_entry_top_test;
  localparam int LVL  = 4;
  localparam bit DEPC = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_req = 0, exc_has_vaddr = 0, dbg_req = 0, sw_we = 0;
  logic [5:0] exc_cause = 0, dbg_cause = 0;
  logic [31:0] evt_pc = 0, exc_vaddr = 0, sw_wdata = 0;
  logic [3:0] sw_idx = 0, rd_idx = 0;
  logic [31:0] rd_data, status_o, cause_o, vaddr_o;
  logic [3:0] vec_sel;

  int checks = 0;
  int failures = 0;
  logic [31:0] m [16];
  logic [3:0] ev;

  always #5 clk = ~clk;

  exc_entry_top #(.DBG_LEVEL(LVL), .HAS_DEPC(DEPC)) uut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_has_vaddr(exc_has_vaddr),
    .exc_cause(exc_cause), .evt_pc(evt_pc), .exc_vaddr(exc_vaddr),
    .dbg_req(dbg_req), .dbg_cause(dbg_cause), .sw_we(sw_we), .sw_idx(sw_idx),
    .sw_wdata(sw_wdata), .rd_idx(rd_idx), .rd_data(rd_data),
    .status_o(status_o), .cause_o(cause_o), .vaddr_o(vaddr_o), .vec_sel(vec_sel)
  );

  task automatic chk(input string what, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Bench model of one clock edge: updates m and ev from the old state.
  task automatic model_step(output string tag);
    logic [31:0] st;
    logic [31:0] n [16];
    bit event_taken;
    st = m[0];
    n = m;
    ev = 4'b0;
    event_taken = 0;
    tag = "R9";
    if (exc_req) begin
      event_taken = 1;
      if (st[4]) begin
        ev = 4'b0100; tag = "R3";
        if (DEPC) n[4] = evt_pc; else n[5] = evt_pc;
      end else begin
        ev = st[5] ? 4'b0001 : 4'b0010; tag = "R2";
        n[5] = evt_pc;
      end
      n[1] = {26'b0, exc_cause};
      n[0] = st | 32'h10;
      if (exc_has_vaddr) n[2] = exc_vaddr;
      if (dbg_req) tag = "R8";
    end else if (dbg_req) begin
      if (st[3:0] < LVL) begin
        event_taken = 1;
        ev = 4'b1000; tag = "R7";
        n[3] = {26'b0, dbg_cause};
        n[4 + LVL] = evt_pc;
        n[9 + LVL] = st;
        n[0] = {st[31:5], 1'b1, 4'(LVL)};
      end else tag = "R6";
    end
    if (sw_we && !event_taken) begin
      if (!(sw_idx == 4 && !DEPC)) n[sw_idx] = sw_wdata;
      if (tag == "R9") tag = "R10";
    end
    m = n;
  endtask

  task automatic cycle(input bit e, input bit va, input logic [5:0] c,
                       input logic [31:0] pc, input logic [31:0] vad,
                       input bit d, input logic [5:0] dc,
                       input bit we, input logic [3:0] wi, input logic [31:0] wd,
                       input logic [3:0] ri);
    string tag;
    exc_req = e; exc_has_vaddr = va; exc_cause = c; evt_pc = pc;
    exc_vaddr = vad; dbg_req = d; dbg_cause = dc;
    sw_we = we; sw_idx = wi; sw_wdata = wd; rd_idx = ri;
    model_step(tag);
    @(negedge clk);
    chk("vec_sel", tag, {28'b0, vec_sel}, {28'b0, ev});
    chk("status", e ? "R4" : tag, status_o, m[0]);
    chk("cause", "R4", cause_o, m[1]);
    chk("vaddr", "R5", vaddr_o, m[2]);
    chk("rd_data", we ? "R10" : tag, rd_data, m[ri]);
    exc_req = 0; dbg_req = 0; sw_we = 0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    cycle(0, 0, 0, 0, 0, 0, 0, 1, idx, d, idx);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m[i] = '0;
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i);
      #1;
      chk("reset rd_data", "R1", rd_data, 32'h0);
    end
    chk("reset vec_sel", "R1", {28'b0, vec_sel}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: user then kernel vector
    wr(0, 32'h0000_0020);
    cycle(1, 1, 6'd9, 32'h1000_0040, 32'hdead_0000, 0, 0, 0, 0, 0, 5);
    wr(0, 32'h0000_0003);
    cycle(1, 0, 6'd3, 32'h1000_0080, 32'h1111_1111, 0, 0, 0, 0, 0, 5);
    // R3: double vector with EXCM already set; EPC1 untouched
    cycle(1, 1, 6'd7, 32'h2000_0000, 32'hbeef_0004, 0, 0, 0, 0, 0, 4);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5);
    // R6: debug ignored at level == LVL
    wr(0, 32'(LVL));
    cycle(0, 0, 0, 32'h3000_0000, 0, 1, 6'd2, 0, 0, 0, 4'(4 + LVL));
    // R7: debug accepted one below LVL, status bits kept
    wr(0, 32'h0000_0120 | 32'(LVL - 1));
    cycle(0, 0, 0, 32'h3000_0010, 0, 1, 6'd5, 0, 0, 0, 4'(9 + LVL));
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'(4 + LVL));
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
    // R8: simultaneous, exception wins
    wr(0, 32'h0);
    cycle(1, 0, 6'd11, 32'h4000_0000, 0, 1, 6'd1, 0, 0, 0, 3);
    // R10: software write dropped on event cycle
    cycle(1, 0, 6'd12, 32'h4000_0100, 0, 0, 0, 1, 4'd11, 32'hcafe_f00d, 11);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 11);

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 3) begin
        logic [31:0] s;
        s = $urandom;
        s[3:0] = 4'($urandom_range(LVL - 2, LVL + 1));
        wr(0, s);
      end else if (r < 4) begin
        wr(4'($urandom), $urandom);
      end else begin
        cycle(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
              6'($urandom), $urandom, $urandom,
              bit'($urandom_range(0, 1)), 6'($urandom),
              bit'($urandom_range(0, 1)), 4'($urandom), $urandom,
              4'($urandom));
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule